// File: doc/BRIEF.md
# Defective-Cell Spare Redirector

This block sits in the path between a memory requester and a DRAM that contains a handful of cells known to be defective. A table of up to sixteen addresses is filled from pretest results before normal traffic starts. During operation, every request address is compared against all valid table entries in parallel.

When an address matches an entry, the access is served by a small on-block spare SRAM and the DRAM never sees it. Entry i owns spare word i. When no entry matches, the request is passed to the DRAM port untouched.

A lock input freezes the table once it has been loaded. Read data always appears at the response port exactly one clock after the request, whichever store supplied it. The DRAM model behind the block is expected to return read data one cycle after it sees the request.

Top module: `spare_remap`

## Requirements
- R1: After reset every table entry is invalid, so the first access to any address is forwarded to the DRAM and its read data comes from the DRAM.
- R2: While `lock` is low, a cycle with `ld_en` high writes `ld_addr` and `ld_valid` into entry `ld_idx`.
- R3: While `lock` is high, `ld_en` has no effect: existing entries keep redirecting and a newly offered address keeps going to the DRAM.
- R4: A read whose address equals the address of a valid entry i returns the contents of spare word i, and `dram_req` stays low in that cycle.
- R5: A write whose address equals the address of a valid entry i stores its data in spare word i, `dram_req` stays low, and the DRAM contents at that address are unchanged.
- R6: A request that matches no valid entry raises `dram_req` in the same cycle, with `dram_we`, `dram_addr` and `dram_wdata` equal to `req_we`, `req_addr` and `req_wdata`.
- R7: The data of a read accepted at one rising edge is on `rsp_rdata` during the following cycle for both hits and misses, including back-to-back reads that alternate between the two paths.
- R8: When several valid entries hold the same address, the entry with the lowest index is used.
- R9: Writing an entry with `ld_valid` low removes it, so its address falls back to the next matching entry, or to the DRAM if no other entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | High freezes the tag table |
| ld_en | input | 1 | Table write strobe |
| ld_idx | input | IW | Entry to write |
| ld_addr | input | AW | Defective address for the entry |
| ld_valid | input | 1 | Valid bit for the entry |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| rsp_rdata | output | DW | Read data, one cycle after the request |
| dram_req | output | 1 | Forwarded request to the DRAM |
| dram_we | output | 1 | Forwarded write enable |
| dram_addr | output | AW | Forwarded address |
| dram_wdata | output | DW | Forwarded write data |
| dram_rdata | input | DW | DRAM read data, one cycle after `dram_req` |

## Verification
The bench aims at duplicated tags. A priority encoder that favours the highest index would return the wrong spare word there. Removing the lower entry then shows whether the fallback reaches the next entry, and removing the last one shows it reaches the DRAM. A write hit that leaked to the DRAM is exposed by reading the DRAM value back after the tag is cleared. Alternating hit and miss reads catch a response mux that selects with the wrong cycle's hit flag. Load attempts made while locked, both adding and clearing entries, catch a lock that is ignored.

// File: rtl/spare_remap.sv
module spare_remap #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_valid,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          dram_req,
  output logic          dram_we,
  output logic [AW-1:0] dram_addr,
  output logic [DW-1:0] dram_wdata,
  input  logic [DW-1:0] dram_rdata
);

  logic [AW-1:0]      tag_a [ENTRIES];
  logic [ENTRIES-1:0] tag_v;
  logic [DW-1:0]      spare [ENTRIES];
  logic [DW-1:0]      spare_q;
  logic               hit, hit_q;
  logic [IW-1:0]      hit_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_v[i] && tag_a[i] == req_addr) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_v <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_a[i] <= '0;
    end else if (ld_en && !lock) begin
      tag_v[ld_idx] <= ld_valid;
      tag_a[ld_idx] <= ld_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && hit && req_we) spare[hit_idx] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      spare_q <= '0;
    end else begin
      hit_q <= req_valid && hit;
      if (req_valid && hit && !req_we) spare_q <= spare[hit_idx];
    end
  end

  assign dram_req   = req_valid && !hit;
  assign dram_we    = req_we;
  assign dram_addr  = req_addr;
  assign dram_wdata = req_wdata;
  assign rsp_rdata  = hit_q ? spare_q : dram_rdata;

  assert_locked_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> $stable(tag_v));

  assert_load_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !lock) |=> tag_v[$past(ld_idx)] == $past(ld_valid));

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !lock && ld_valid) |=> tag_a[$past(ld_idx)] == $past(ld_addr));

  assert_dram_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |-> req_valid);

  assert_miss_selects_dram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |=> !hit_q);

  assert_hit_selects_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dram_req) |=> hit_q);

endmodule

// File: tb/spare_remap_bench.sv
module spare_remap_bench;
  localparam int AW = 16, DW = 16, ENTRIES = 16, IW = 4;

  logic clk = 0, rst_n = 0, lock = 0;
  logic ld_en = 0, ld_valid = 0;
  logic [IW-1:0] ld_idx = '0;
  logic [AW-1:0] ld_addr = '0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, dram_wdata, dram_q;
  logic dram_req, dram_we;
  logic [AW-1:0] dram_addr;
  logic [DW-1:0] mem [256];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spare_remap #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES)) u_spare_remap (
    .clk(clk), .rst_n(rst_n), .lock(lock), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_addr(ld_addr), .ld_valid(ld_valid), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .dram_req(dram_req), .dram_we(dram_we),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_q));

  always @(posedge clk) begin
    if (dram_req) begin
      if (dram_we) mem[dram_addr[7:0]] <= dram_wdata;
      else dram_q <= mem[dram_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input int addr, input bit v);
    @(negedge clk);
    ld_en = 1; ld_idx = IW'(idx); ld_addr = AW'(addr); ld_valid = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  // Called at a negedge; leaves the bench at the next negedge with the request still driven.
  task automatic access(input bit we, input int addr, input int wd,
                        input bit exp_dram, input int exp_rd, input string req);
    req_valid = 1; req_we = we; req_addr = AW'(addr); req_wdata = DW'(wd);
    #1;
    check(dram_req == exp_dram, {req, " dram_req"}, int'(dram_req), int'(exp_dram));
    @(negedge clk);
    if (!we) check(rsp_rdata == DW'(exp_rd), {req, " rsp_rdata"}, int'(rsp_rdata), exp_rd);
  endtask

  task automatic idle();
    req_valid = 0; req_we = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    access(0, 'h10, 0, 1, 'h31, "R1 reset miss");
    idle();
  endtask

  task automatic t_miss();
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 'h20; req_wdata = 'h1234;
    #1;
    check(dram_req && dram_we && dram_addr == 'h20 && dram_wdata == 'h1234,
          "R6 forwarded write", int'(dram_wdata), 'h1234);
    @(negedge clk);
    access(0, 'h20, 0, 1, 'h1234, "R6 R7 miss read");
    idle();
  endtask

  task automatic t_hit();
    load(2, 'h40, 1);
    access(1, 'h40, 'hBEEF, 0, 0, "R2 R5 write hit");
    access(0, 'h40, 0, 0, 'hBEEF, "R4 read hit");
    access(0, 'h41, 0, 1, 'h41 * 3 + 1, "R7 miss after hit");
    access(0, 'h40, 0, 0, 'hBEEF, "R7 hit after miss");
    idle();
  endtask

  task automatic t_priority();
    @(negedge clk);
    access(1, 'h50, 'hAAAA, 1, 0, "R6 dram preset");
    idle();
    load(7, 'h50, 1);
    access(1, 'h50, 'h7777, 0, 0, "R5 write entry7");
    idle();
    load(3, 'h50, 1);
    access(1, 'h50, 'h3333, 0, 0, "R8 write dup");
    access(0, 'h50, 0, 0, 'h3333, "R8 lowest entry wins");
    idle();
    load(3, 'h50, 0);
    access(0, 'h50, 0, 0, 'h7777, "R9 fallback to entry7");
    idle();
    load(7, 'h50, 0);
    access(0, 'h50, 0, 1, 'hAAAA, "R9 R5 fallback to dram");
    idle();
  endtask

  task automatic t_lock();
    lock = 1;
    load(9, 'h60, 1);
    load(2, 'h40, 0);
    access(0, 'h60, 0, 1, 'h60 * 3 + 1, "R3 locked load ignored");
    access(0, 'h40, 0, 0, 'hBEEF, "R3 locked clear ignored");
    idle();
    lock = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 1);
    dram_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_miss();
    t_hit();
    t_priority();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule